// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

An eight-pin general-purpose I/O port controlled through a small synchronous register bus. Each pin is an input or an output, chosen by its direction bit. Output pins drive the value held in the data register. A read of the data register gives back the stored bit for output pins and the synchronized pad level for input pins.

Every pin feeds an edge detector through a two-flop synchronizer. A polarity bit selects the edge that counts for each pin: rising or falling. When that edge arrives, the pin's interrupt flag is latched. Software clears a flag by writing 1 to it. A single interrupt line is raised while any pin has both its flag and its enable bit set. Edges are detected on every pin, whatever its direction, so an output pin whose pad level is fed back can also raise an interrupt.

The register map uses byte addresses: 0 data, 1 direction (1 = output), 2 interrupt enable (1 = enabled), 3 polarity (1 = rising, 0 = falling), 4 flags. The map sits behind separate write and read strobes. Read data appears on the clock edge after the read strobe and holds until the next read.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register (data, direction, enable, polarity, flags) is 0. pin_oe_o, pin_out_o and irq_o are 0, and reads of addresses 0 to 4 return 0 while pin_i is held at 0.
- R2: pin_oe_o equals the direction register and pin_out_o equals the data register. Both follow a write one cycle after the write strobe.
- R3: A read of address 0 returns the data register bit where the direction bit is 1. Where the direction bit is 0, it returns the synchronized pin_i bit.
- R4: Read data appears on rdata_o one cycle after rd_en_i and holds until the next read. Addresses 1 to 4 read back the stored register. Addresses 5 to 7 read as 0, and writes to them change no register.
- R5: With polarity bit 1, a rising pin edge sets the pin's flag. With polarity bit 0, a falling edge sets it. An edge of the other direction leaves the flag unchanged. A change on pin_i shows in the flags no later than the fourth clock edge after it.
- R6: Writing address 4 clears each flag bit written as 1. Bits written as 0 keep their value.
- R7: If an active edge is detected on a bit in the same cycle that a clearing write hits that bit, the flag stays 1.
- R8: irq_o is 1 exactly when some pin has both its flag bit and its enable bit set.
- R9: Edge detection and flag setting also work on pins whose direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after rd_en_i |
| pin_i | input | 8 | Pad input levels |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin output value |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that wr_en_i, rd_en_i, addr_i and wdata_i are stable around the sampling edge. They also assume that pin_i is low while reset is asserted, since the synchronizer and the previous-sample register come out of reset at 0. The bench changes every input only on the falling clock edge and keeps pin_i at 0 through reset. It holds each pin level for at least four cycles so that every edge travels through the synchronizer before the flags are read. The one deliberate collision, where an edge and a clearing write land together, is timed by counting cycles from the pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_IEN  = 3'd2,
    REG_POL  = 3'd3,
    REG_FLAG = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,   // synchronized pin level
  input  logic [W-1:0] pol_i,   // 1 = rising, 0 = falling
  input  logic [W-1:0] clr_i,   // write-one-to-clear mask
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign hit[g] = pol_i[g] ? (lvl_i[g] & ~prev_q[g]) : (~lvl_i[g] & prev_q[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q[g] <= 1'b0;
      else if (hit[g]) flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |hit |=> ((flag_o & $past(hit)) == $past(hit)))  // R5
    else $error("edge did not set flag");
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(hit & clr_i) |=> ((flag_o & $past(hit & clr_i)) == $past(hit & clr_i)))  // R7
    else $error("clear beat a new edge");
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~hit) |=> ((flag_o & $past(clr_i & ~hit)) == '0))  // R6
    else $error("flag not cleared");
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0 && clr_i == '0) |=> $stable(flag_o))  // R6
    else $error("flag changed without cause");
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] data_q, dir_q, ien_q, pol_q;
  logic [NUM_PINS-1:0] pin_sync, flag, clr_mask, rd_mux;

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign clr_mask = (wr_en_i && addr_i == REG_FLAG) ? wdata_i : '0;

  gpio_edge_flags #(.W(NUM_PINS)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_sync),
    .pol_i (pol_q),
    .clr_i (clr_mask),
    .flag_o(flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      pol_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_DATA: data_q <= wdata_i;
        REG_DIR:  dir_q  <= wdata_i;
        REG_IEN:  ien_q  <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      REG_DATA: rd_mux = (data_q & dir_q) | (pin_sync & ~dir_q);
      REG_DIR:  rd_mux = dir_q;
      REG_IEN:  rd_mux = ien_q;
      REG_POL:  rd_mux = pol_q;
      REG_FLAG: rd_mux = flag;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign pin_oe_o  = dir_q;
  assign pin_out_o = data_q;
  assign irq_o     = |(flag & ien_q);

  AST_OE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR) |=> (pin_oe_o == $past(wdata_i)))  // R2
    else $error("output enable did not follow write");
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o))  // R4
    else $error("read data changed without strobe");
  AST_RD_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i > REG_FLAG) |=> (rdata_o == '0))  // R4
    else $error("unmapped read not zero");
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (ien_q != '0 && flag != '0))  // R8
    else $error("irq without flag and enable");
endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pin = '0;
  logic [7:0] rdata, oe, pout;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  gpio_edge_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin),
    .pin_oe_o(oe), .pin_out_o(pout), .irq_o(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push expected value, strobe read
  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare read data one cycle after strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4: unexpected read data %02h expected none", rdata);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    check("R1 oe", oe, 8'h00);
    check("R1 out", pout, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, "R1 reg");

    // R2 outputs, R3 data read mux
    wr(3'd1, 8'hF0);
    check("R2 oe", oe, 8'hF0);
    wr(3'd0, 8'hA5);
    check("R2 out", pout, 8'hA5);
    pin = 8'h0C;
    cyc(4);
    rd(3'd0, 8'hAC, "R3 mixed");
    rd(3'd1, 8'hF0, "R4 dir readback");

    // R5 polarity: low nibble rising, rest falling
    wr(3'd3, 8'h0F);
    rd(3'd3, 8'h0F, "R4 pol readback");
    pin = 8'h03;  // bits 0,1 rise; bits 2,3 fall (inactive)
    cyc(4);
    rd(3'd4, 8'h03, "R5 rising");
    pin = 8'h00;  // falls on rising-select pins
    cyc(4);
    rd(3'd4, 8'h03, "R5 inactive edge");
    pin = 8'h80;  // rise on falling-select pin
    cyc(4);
    rd(3'd4, 8'h03, "R5 inactive rise");
    pin = 8'h00;
    cyc(4);
    rd(3'd4, 8'h83, "R5 falling");

    // R8 interrupt
    cyc(1);
    check("R8 irq disabled", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'h80);
    check("R8 irq enabled", {7'd0, irq}, 8'h01);

    // R6 write-one-to-clear
    wr(3'd4, 8'h80);
    check("R8 irq after clear", {7'd0, irq}, 8'h00);
    rd(3'd4, 8'h03, "R6 clear bit7");
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h03, "R6 zero write");
    wr(3'd4, 8'h01);
    rd(3'd4, 8'h02, "R6 clear bit0");

    // R9 edge on output pin 4 (falling select)
    pin = 8'h10;
    cyc(4);
    rd(3'd4, 8'h02, "R9 inactive rise");
    pin = 8'h00;
    cyc(4);
    rd(3'd4, 8'h12, "R9 output-mode fall");

    // R7 set wins: edge on bit0 lands with clear of bits 0,1
    pin = 8'h01;            // driven after a negedge
    @(negedge clk);         // sync stage 1 loaded
    @(negedge clk);         // stage 2 loaded, edge detected now
    wr_en = 1'b1; addr = 3'd4; wdata = 8'h03;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd4, 8'h11, "R7 set wins");

    // R8 OR over pins
    wr(3'd2, 8'h11);
    check("R8 two sources", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h10);
    check("R8 one source left", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h01);
    check("R8 none left", {7'd0, irq}, 8'h00);

    // R4 unmapped addresses
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd5, 8'h00, "R4 unmapped read");
    rd(3'd1, 8'hF0, "R4 dir untouched");
    rd(3'd2, 8'h11, "R4 ien untouched");
    rd(3'd0, 8'hA1, "R4 data untouched");
    cyc(2);
    check("R4 rdata hold", rdata, 8'hA1);

    cyc(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R4: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule